// File: doc/BRIEF.md
# External Interrupt Conditioner with Idle Wake-Up

This block sits between one active-low external interrupt pin and a processor core that can stop its clocks. While the core's clocks run, the pin is brought into the clock domain through a two-flop synchronizer. A falling edge is then qualified against minimum low and high durations, and each accepted low phase turns into exactly one single-cycle interrupt request.

When the core and its clock-generation domain both report idle, the detector changes character. A low level on the pin starts a wake-up countdown, whose length is given by the `start_dly` input in clock cycles. When the countdown ends, the block raises a clock-generation enable, and it holds that enable until the clock domain reports that it is running again. From then on the pin stays level-sensitive: for as long as it remains low, an interrupt request repeats at a fixed interval. The first rising edge of the pin after wake-up returns the detector to edge qualification.

Top module: `extint_wake`

## Requirements
- R1: Asynchronous active-low reset clears `irq` and `clkgen_en` and selects edge mode. A low phase of 20 cycles after reset produces a single pulse.
- R2: The pin passes through two flops before any qualification. In edge mode, if the pin is first sampled low at rising edge E0 and is still low at E1 and E2, `irq` is high in the cycle after edge E4 and low before it.
- R3: `irq` is high for one cycle only. In edge mode a low phase yields exactly one pulse, however long it lasts.
- R4: In edge mode, a low phase shorter than three sampled cycles produces no pulse.
- R5: After a qualified low, the pin must be sampled high on at least two consecutive cycles before another low can qualify. After a single high sample, the following low is ignored.
- R6: With `cpu_idle` high and `clk_idle` low, the detector stays in edge mode, and a qualified low still produces one pulse.
- R7: Level mode is entered only on a rising edge where `cpu_idle` and `clk_idle` are both high. `clk_idle` alone starts no wake-up countdown. No `irq` is issued in a cycle that follows a sampled-high `clk_idle`.
- R8: In level mode with `clk_idle` high, `clkgen_en` rises at rising edge E(2+D) when the pin is first sampled low at E0, where D is `start_dly`.
- R9: `clkgen_en` stays high while `clk_idle` is high, and it drops on the first rising edge at which `clk_idle` is sampled low.
- R10: In level mode with `clk_idle` low, a low synchronized pin issues a pulse on its first cycle and then one every REPEAT cycles (default 8).
- R11: The first rising edge of the synchronized pin after `clk_idle` falls restores edge mode, so a following long low produces only one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| cpu_idle | input | 1 | Core is in an idle state |
| clk_idle | input | 1 | Clock-generation domain is idle |
| start_dly | input | DLY_W | Wake-up countdown length in clock cycles |
| irq | output | 1 | Single-cycle interrupt request |
| clkgen_en | output | 1 | Request to restart clock generation |

## Verification
In edge mode, the block is driven with short, threshold-length and long low phases, each separated by high gaps of one, two or more cycles. These patterns separate the three-sample low rule, the two-sample high rule and the one-pulse-per-low rule. The same 20-cycle low is then applied in three situations: running, after a clock-idle flag raised alone, and after a real wake-up. Only the real wake-up may give three pulses, which separates level mode from edge mode. The wake-up path is timed to the exact cycle against the countdown value, and a reset is issued while the clock-generation enable is high.

// File: rtl/extint_wake.sv
`timescale 1ns/1ps
module extint_wake #(
  parameter int DLY_W  = 16,
  parameter int REPEAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_n,
  input  logic             cpu_idle,
  input  logic             clk_idle,
  input  logic [DLY_W-1:0] start_dly,
  output logic             irq,
  output logic             clkgen_en
);
  localparam int RW = (REPEAT > 2) ? $clog2(REPEAT) : 1;
  localparam logic [RW-1:0] REP_LAST = RW'(REPEAT - 1);

  logic             s1, s2;
  logic [1:0]       low_run, high_run;
  logic             armed, lvl;
  logic [DLY_W-1:0] dly;
  logic [RW-1:0]    rep;
  logic             pin_s, edge_fire, lvl_fire, rise, wake_cnt, lvl_low;

  assign pin_s     = s2;
  assign rise      = pin_s && (high_run == 2'd0);
  assign lvl_low   = lvl && !clk_idle && !pin_s;
  assign edge_fire = !lvl && !clk_idle && !pin_s && (low_run == 2'd2) && armed;
  assign lvl_fire  = lvl_low && (rep == '0);
  assign wake_cnt  = lvl && clk_idle && !pin_s && !clkgen_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1        <= 1'b1;
      s2        <= 1'b1;
      low_run   <= '0;
      high_run  <= '0;
      armed     <= 1'b0;
      lvl       <= 1'b0;
      dly       <= '0;
      rep       <= '0;
      irq       <= 1'b0;
      clkgen_en <= 1'b0;
    end else begin
      s1 <= pin_n;
      s2 <= s1;

      if (pin_s)                low_run <= '0;
      else if (low_run != 2'd3) low_run <= low_run + 2'd1;

      if (!pin_s)                high_run <= '0;
      else if (high_run != 2'd3) high_run <= high_run + 2'd1;

      if (edge_fire)                         armed <= 1'b0;
      else if (pin_s && high_run != 2'd0)    armed <= 1'b1;

      if (cpu_idle && clk_idle)              lvl <= 1'b1;
      else if (lvl && !clk_idle && rise)     lvl <= 1'b0;

      if (wake_cnt) dly <= dly + 1'b1;
      else          dly <= '0;

      if (!clk_idle)                         clkgen_en <= 1'b0;
      else if (wake_cnt && dly == start_dly) clkgen_en <= 1'b1;

      if (lvl_low) rep <= (rep == REP_LAST) ? '0 : rep + 1'b1;
      else         rep <= '0;

      irq <= edge_fire | lvl_fire;
    end
  end
endmodule

// File: rtl/extint_wake_chk.sv
`timescale 1ns/1ps
module extint_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_n,
  input logic clk_idle,
  input logic irq,
  input logic clkgen_en
);
  a_r3_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r2_pulse_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$past(pin_n, 3));

  a_r7_quiet_while_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clk_idle) |-> !irq);

  a_r8_enable_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkgen_en) |-> $past(clk_idle));

  a_r9_enable_released: assert property (@(posedge clk) disable iff (!rst_n)
    (clkgen_en && !clk_idle) |=> !clkgen_en);
endmodule

bind extint_wake extint_wake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .clk_idle(clk_idle),
  .irq(irq), .clkgen_en(clkgen_en)
);

// File: tb/extint_wake_bench.sv
`timescale 1ns/1ps
module extint_wake_bench;
  localparam int D = 5;

  logic clk = 1'b0;
  logic rst_n, pin_n, cpu_idle, clk_idle;
  logic [15:0] start_dly;
  logic irq, clkgen_en;
  int n_cmp = 0, n_bad = 0, pulses = 0, base = 0;
  bit done = 1'b0;

  // primer low 3, high h, low l, high 6; expected pulse total
  localparam int VEC [8][3] = '{
    '{4, 3, 2}, '{4, 2, 1}, '{4, 20, 2}, '{1, 5, 1},
    '{2, 3, 2}, '{3, 4, 2}, '{2, 2, 1}, '{1, 1, 1}
  };

  extint_wake u_extint_wake (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .cpu_idle(cpu_idle),
    .clk_idle(clk_idle), .start_dly(start_dly), .irq(irq), .clkgen_en(clkgen_en)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (irq) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    pin_n = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got hung expected done");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; pin_n = 1'b1; cpu_idle = 1'b0; clk_idle = 1'b0; start_dly = 16'(D);
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 clkgen_en in reset", int'(clkgen_en), 0);
    rst_n = 1'b1;
    hold(1'b1, 4);

    // R3 R4 R5 edge qualification table
    for (int i = 0; i < 8; i++) begin
      base = pulses;
      hold(1'b0, 3);
      hold(1'b1, VEC[i][0]);
      hold(1'b0, VEC[i][1]);
      hold(1'b1, 6);
      chk($sformatf("R3/R4/R5 vector %0d", i), pulses - base, VEC[i][2]);
    end

    // R2 exact latency, R3 width
    pin_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 irq before fourth edge", int'(irq), 0);
    @(negedge clk);
    chk("R2 irq after fourth edge", int'(irq), 1);
    @(negedge clk);
    chk("R3 irq one cycle", int'(irq), 0);
    hold(1'b1, 6);

    // R6 cpu idle only
    cpu_idle = 1'b1;
    base = pulses;
    hold(1'b0, 4);
    hold(1'b1, 6);
    chk("R6 wake by edge pulse count", pulses - base, 1);
    chk("R6 no clkgen_en", int'(clkgen_en), 0);
    cpu_idle = 1'b0;

    // R7 clk_idle alone ignored
    clk_idle = 1'b1;
    hold(1'b1, 2);
    base = pulses;
    hold(1'b0, D + 10);
    chk("R7 no countdown on clk_idle alone", int'(clkgen_en), 0);
    chk("R7 no irq while clk_idle", pulses - base, 0);
    hold(1'b1, 1);
    clk_idle = 1'b0;
    hold(1'b1, 4);
    base = pulses;
    hold(1'b0, 20);
    hold(1'b1, 6);
    chk("R7 still edge mode", pulses - base, 1);

    // R8 wake countdown
    cpu_idle = 1'b1; clk_idle = 1'b1;
    hold(1'b1, 3);
    base = pulses;
    pin_n = 1'b0;
    repeat (D + 2) @(negedge clk);
    chk("R8 enable not yet", int'(clkgen_en), 0);
    @(negedge clk);
    chk("R8 enable at E(2+D)", int'(clkgen_en), 1);
    repeat (3) @(negedge clk);
    chk("R9 enable held while clk_idle", int'(clkgen_en), 1);
    chk("R7 no irq during wake countdown", pulses - base, 0);

    // R9 R10 level repeat
    clk_idle = 1'b0; cpu_idle = 1'b0;
    base = pulses;
    @(negedge clk);
    chk("R9 enable dropped", int'(clkgen_en), 0);
    repeat (19) @(negedge clk);
    hold(1'b1, 10);
    chk("R10 repeated pulses in level mode", pulses - base, 3);

    // R11 back to edge mode
    base = pulses;
    hold(1'b0, 20);
    hold(1'b1, 6);
    chk("R11 single pulse after exit", pulses - base, 1);

    // R1 reset during wake
    cpu_idle = 1'b1; clk_idle = 1'b1;
    hold(1'b1, 3);
    hold(1'b0, D + 6);
    chk("R8 enable before reset", int'(clkgen_en), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 enable cleared by reset", int'(clkgen_en), 0);
    chk("R1 irq cleared by reset", int'(irq), 0);
    cpu_idle = 1'b0; clk_idle = 1'b0;
    pin_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    hold(1'b1, 4);
    base = pulses;
    hold(1'b0, 20);
    hold(1'b1, 6);
    chk("R1 edge mode after reset", pulses - base, 1);

    done = 1'b1;
    report();
  end
endmodule